// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

This block is a synchronous RAM with two fully independent access ports, named left and right, that share one clock. Each port has its own address, write data, read data, write strobe, a pair of chip enables (one active-low, one active-high) and per-byte select inputs. Both ports can reach any word in the same cycle. Reads are registered, and bytes that are not selected come back as zero.

The two highest words are reserved as mailboxes for passing messages between the ports. When one port writes the mailbox that belongs to the other port, the other port sees its active-low interrupt line go low. That interrupt stays low until the owning port reads its own mailbox. An asynchronous active-low master reset clears both interrupts and the read registers. It must be applied at power-up. The storage array itself is not cleared by reset.

Top module: `dpm_mailbox_ram`

## Requirements
- R1: A write by an enabled port changes only the bytes whose select bit is high. Byte b covers data bits [8b+7:8b]. The other bytes of the word keep their previous value.
- R2: A read by an enabled port returns the word on the read data output one clock after the address is sampled. Bytes whose select bit is low read as zero.
- R3: A port is enabled only in a cycle where its active-low enable is low and its active-high enable is high. In any other cycle the port writes nothing, and one clock later its read data is zero. A single enabled read cycle brings valid data back.
- R4: Both ports operate in the same cycle. A read of a word that the other port writes in that same cycle returns the word's previous content.
- R5: The highest address (all ones) is the left mailbox. A write there by the enabled right port drives the left interrupt low from the next clock on.
- R6: The address one below the highest is the right mailbox. A write there by the enabled left port drives the right interrupt low from the next clock on.
- R7: A read of its own mailbox by the enabled owning port returns that port's interrupt high at the next clock.
- R8: When a set event and a clear event for the same interrupt happen in one cycle, the interrupt is low after that clock.
- R9: While the master reset is low, both interrupts are high and both read outputs are zero. This takes effect without waiting for a clock.
- R10: Three actions leave an interrupt unchanged: a port writing its own mailbox, a port reading the other port's mailbox, and a cycle with neither a set event nor a clear event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| mrst_n | input | 1 | Asynchronous master reset, active low |
| l_ce0_n | input | 1 | Left active-low chip enable |
| l_ce1 | input | 1 | Left active-high chip enable |
| l_wr | input | 1 | Left write (1) or read (0) |
| l_be | input | BYTES | Left byte selects |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | BYTES*BYTE_W | Left write data |
| l_rdata | output | BYTES*BYTE_W | Left registered read data |
| l_int_n | output | 1 | Left mailbox interrupt, active low |
| r_ce0_n | input | 1 | Right active-low chip enable |
| r_ce1 | input | 1 | Right active-high chip enable |
| r_wr | input | 1 | Right write (1) or read (0) |
| r_be | input | BYTES | Right byte selects |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | BYTES*BYTE_W | Right write data |
| r_rdata | output | BYTES*BYTE_W | Right registered read data |
| r_int_n | output | 1 | Right mailbox interrupt, active low |

## Verification
Two pairs of functions can coincide in a single cycle. The first pair is a write to a mailbox by one port and a read of that same mailbox by its owner, which sets and clears the same interrupt at once. The second pair is a write by one port and a read by the other port of an ordinary word. The bench drives both ports in one clock to provoke each case. In the first case it judges that the interrupt stays low and that the read returns the old message. In the second case it judges that the read returns the word as it stood before the write. The bench also sweeps every byte-select pattern over every non-mailbox address against a word model it keeps itself.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    localparam int ADDR_W_DEF = 4;
    localparam int BYTES_DEF  = 2;
    localparam int BYTE_W_DEF = 8;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        logic set;
        logic clr;
    } flag_evt_t;

    function automatic logic port_on(input logic ce0_n, input logic ce1);
        return !ce0_n && ce1;
    endfunction

    // a set event has priority over a clear event
    function automatic logic next_flag(input logic cur, input flag_evt_t evt);
        if (evt.set)
            return 1'b1;
        else if (evt.clr)
            return 1'b0;
        else
            return cur;
    endfunction

endpackage

// File: rtl/dpm_port_ctl.sv
module dpm_port_ctl
    import dpm_pkg::*;
(
    input  logic ce0_n,
    input  logic ce1,
    input  logic wr,
    output op_e  op
);

    always_comb begin
        if (!port_on(ce0_n, ce1))
            op = OP_IDLE;
        else if (wr)
            op = OP_WRITE;
        else
            op = OP_READ;
    end

endmodule

// File: rtl/dpm_array.sv
module dpm_array
    import dpm_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int BYTES  = BYTES_DEF,
    parameter int BYTE_W = BYTE_W_DEF
) (
    input  logic                    clk,
    input  logic                    mrst_n,
    input  op_e                     l_op,
    input  logic [BYTES-1:0]        l_be,
    input  logic [ADDR_W-1:0]       l_addr,
    input  logic [BYTES*BYTE_W-1:0] l_wdata,
    output logic [BYTES*BYTE_W-1:0] l_q,
    input  op_e                     r_op,
    input  logic [BYTES-1:0]        r_be,
    input  logic [ADDR_W-1:0]       r_addr,
    input  logic [BYTES*BYTE_W-1:0] r_wdata,
    output logic [BYTES*BYTE_W-1:0] r_q
);

    localparam int DATA_W = BYTES * BYTE_W;
    localparam int DEPTH  = 2 ** ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] l_mask, r_mask;

    for (genvar b = 0; b < BYTES; b++) begin : g_mask
        assign l_mask[b*BYTE_W +: BYTE_W] = {BYTE_W{l_be[b]}};
        assign r_mask[b*BYTE_W +: BYTE_W] = {BYTE_W{r_be[b]}};
    end

    always_ff @(posedge clk) begin
        for (int b = 0; b < BYTES; b++) begin
            if (l_op == OP_WRITE && l_be[b])
                mem[l_addr][b*BYTE_W +: BYTE_W] <= l_wdata[b*BYTE_W +: BYTE_W];
            if (r_op == OP_WRITE && r_be[b])
                mem[r_addr][b*BYTE_W +: BYTE_W] <= r_wdata[b*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            l_q <= '0;
            r_q <= '0;
        end else begin
            l_q <= (l_op == OP_READ) ? (mem[l_addr] & l_mask) : '0;
            r_q <= (r_op == OP_READ) ? (mem[r_addr] & r_mask) : '0;
        end
    end

endmodule

// File: rtl/dpm_mailbox.sv
module dpm_mailbox
    import dpm_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  op_e               l_op,
    input  logic [ADDR_W-1:0] l_addr,
    input  op_e               r_op,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_int_n,
    output logic              r_int_n
);

    localparam logic [ADDR_W-1:0] L_BOX = ADDR_W'((2 ** ADDR_W) - 1);
    localparam logic [ADDR_W-1:0] R_BOX = ADDR_W'((2 ** ADDR_W) - 2);

    flag_evt_t l_evt, r_evt;
    logic      l_flag, r_flag;

    always_comb begin
        l_evt.set = (r_op == OP_WRITE) && (r_addr == L_BOX);
        l_evt.clr = (l_op == OP_READ)  && (l_addr == L_BOX);
        r_evt.set = (l_op == OP_WRITE) && (l_addr == R_BOX);
        r_evt.clr = (r_op == OP_READ)  && (r_addr == R_BOX);
    end

    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            l_flag <= 1'b0;
            r_flag <= 1'b0;
        end else begin
            l_flag <= next_flag(l_flag, l_evt);
            r_flag <= next_flag(r_flag, r_evt);
        end
    end

    assign l_int_n = ~l_flag;
    assign r_int_n = ~r_flag;

endmodule

// File: rtl/dpm_mailbox_ram.sv
module dpm_mailbox_ram
    import dpm_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int BYTES  = BYTES_DEF,
    parameter int BYTE_W = BYTE_W_DEF
) (
    input  logic                    clk,
    input  logic                    mrst_n,
    input  logic                    l_ce0_n,
    input  logic                    l_ce1,
    input  logic                    l_wr,
    input  logic [BYTES-1:0]        l_be,
    input  logic [ADDR_W-1:0]       l_addr,
    input  logic [BYTES*BYTE_W-1:0] l_wdata,
    output logic [BYTES*BYTE_W-1:0] l_rdata,
    output logic                    l_int_n,
    input  logic                    r_ce0_n,
    input  logic                    r_ce1,
    input  logic                    r_wr,
    input  logic [BYTES-1:0]        r_be,
    input  logic [ADDR_W-1:0]       r_addr,
    input  logic [BYTES*BYTE_W-1:0] r_wdata,
    output logic [BYTES*BYTE_W-1:0] r_rdata,
    output logic                    r_int_n
);

    op_e l_op, r_op;

    dpm_port_ctl u_l_ctl (
        .ce0_n (l_ce0_n),
        .ce1   (l_ce1),
        .wr    (l_wr),
        .op    (l_op)
    );

    dpm_port_ctl u_r_ctl (
        .ce0_n (r_ce0_n),
        .ce1   (r_ce1),
        .wr    (r_wr),
        .op    (r_op)
    );

    dpm_array #(
        .ADDR_W (ADDR_W),
        .BYTES  (BYTES),
        .BYTE_W (BYTE_W)
    ) u_array (
        .clk     (clk),
        .mrst_n  (mrst_n),
        .l_op    (l_op),
        .l_be    (l_be),
        .l_addr  (l_addr),
        .l_wdata (l_wdata),
        .l_q     (l_rdata),
        .r_op    (r_op),
        .r_be    (r_be),
        .r_addr  (r_addr),
        .r_wdata (r_wdata),
        .r_q     (r_rdata)
    );

    dpm_mailbox #(
        .ADDR_W (ADDR_W)
    ) u_mailbox (
        .clk     (clk),
        .mrst_n  (mrst_n),
        .l_op    (l_op),
        .l_addr  (l_addr),
        .r_op    (r_op),
        .r_addr  (r_addr),
        .l_int_n (l_int_n),
        .r_int_n (r_int_n)
    );

endmodule

// File: rtl/dpm_mailbox_ram_chk.sv
module dpm_mailbox_ram_chk #(
    parameter int ADDR_W = 4,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8
) (
    input logic                    clk,
    input logic                    mrst_n,
    input logic                    l_ce0_n,
    input logic                    l_ce1,
    input logic                    l_wr,
    input logic [ADDR_W-1:0]       l_addr,
    input logic [BYTES*BYTE_W-1:0] l_rdata,
    input logic                    l_int_n,
    input logic                    r_ce0_n,
    input logic                    r_ce1,
    input logic                    r_wr,
    input logic [ADDR_W-1:0]       r_addr,
    input logic [BYTES*BYTE_W-1:0] r_rdata,
    input logic                    r_int_n
);

    localparam logic [ADDR_W-1:0] L_BOX = ADDR_W'((2 ** ADDR_W) - 1);
    localparam logic [ADDR_W-1:0] R_BOX = ADDR_W'((2 ** ADDR_W) - 2);

    logic l_on, r_on;
    logic l_set, l_clr, r_set, r_clr;
    assign l_on  = !l_ce0_n && l_ce1;
    assign r_on  = !r_ce0_n && r_ce1;
    assign l_set = r_on && r_wr && (r_addr == L_BOX);
    assign l_clr = l_on && !l_wr && (l_addr == L_BOX);
    assign r_set = l_on && l_wr && (l_addr == R_BOX);
    assign r_clr = r_on && !r_wr && (r_addr == R_BOX);

    a_r3_left_idle_zero: assert property (@(posedge clk) disable iff (!mrst_n)
        !l_on |=> (l_rdata == '0));
    a_r3_right_idle_zero: assert property (@(posedge clk) disable iff (!mrst_n)
        !r_on |=> (r_rdata == '0));
    a_r5_left_set: assert property (@(posedge clk) disable iff (!mrst_n)
        l_set |=> !l_int_n);
    a_r6_right_set: assert property (@(posedge clk) disable iff (!mrst_n)
        r_set |=> !r_int_n);
    a_r7_left_clear: assert property (@(posedge clk) disable iff (!mrst_n)
        (l_clr && !l_set) |=> l_int_n);
    a_r7_right_clear: assert property (@(posedge clk) disable iff (!mrst_n)
        (r_clr && !r_set) |=> r_int_n);
    a_r8_left_set_wins: assert property (@(posedge clk) disable iff (!mrst_n)
        (l_clr && l_set) |=> !l_int_n);
    a_r10_left_hold: assert property (@(posedge clk) disable iff (!mrst_n)
        (!l_set && !l_clr) |=> $stable(l_int_n));
    a_r10_right_hold: assert property (@(posedge clk) disable iff (!mrst_n)
        (!r_set && !r_clr) |=> $stable(r_int_n));
    a_r9_reset_state: assert property (@(posedge clk)
        !mrst_n |-> (l_int_n && r_int_n && l_rdata == '0 && r_rdata == '0));

endmodule

bind dpm_mailbox_ram dpm_mailbox_ram_chk #(
    .ADDR_W (ADDR_W),
    .BYTES  (BYTES),
    .BYTE_W (BYTE_W)
) u_chk (
    .clk     (clk),
    .mrst_n  (mrst_n),
    .l_ce0_n (l_ce0_n),
    .l_ce1   (l_ce1),
    .l_wr    (l_wr),
    .l_addr  (l_addr),
    .l_rdata (l_rdata),
    .l_int_n (l_int_n),
    .r_ce0_n (r_ce0_n),
    .r_ce1   (r_ce1),
    .r_wr    (r_wr),
    .r_addr  (r_addr),
    .r_rdata (r_rdata),
    .r_int_n (r_int_n)
);

// File: tb/dpm_mailbox_ram_tb.sv
module dpm_mailbox_ram_tb;

    localparam int AW    = 4;
    localparam int NB    = 2;
    localparam int BW    = 8;
    localparam int DW    = NB * BW;
    localparam int DEPTH = 2 ** AW;
    localparam logic [AW-1:0] L_BOX = AW'(DEPTH - 1);
    localparam logic [AW-1:0] R_BOX = AW'(DEPTH - 2);

    logic          clk = 1'b0;
    logic          mrst_n;
    logic          l_ce0_n, l_ce1, l_wr, r_ce0_n, r_ce1, r_wr;
    logic [NB-1:0] l_be, r_be;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
    logic          l_int_n, r_int_n;

    logic [DW-1:0] model [DEPTH];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    dpm_mailbox_ram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) u_dut (
        .clk(clk), .mrst_n(mrst_n),
        .l_ce0_n(l_ce0_n), .l_ce1(l_ce1), .l_wr(l_wr), .l_be(l_be),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_int_n(l_int_n),
        .r_ce0_n(r_ce0_n), .r_ce1(r_ce1), .r_wr(r_wr), .r_be(r_be),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_int_n(r_int_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] bmask(input logic [NB-1:0] be);
        logic [DW-1:0] m;
        for (int b = 0; b < NB; b++) m[b*BW +: BW] = {BW{be[b]}};
        return m;
    endfunction

    task automatic idle();
        l_ce0_n = 1'b1; l_ce1 = 1'b0; l_wr = 1'b0; l_be = '0; l_addr = '0; l_wdata = '0;
        r_ce0_n = 1'b1; r_ce1 = 1'b0; r_wr = 1'b0; r_be = '0; r_addr = '0; r_wdata = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic lset(input logic wr, input logic [NB-1:0] be, input logic [AW-1:0] a,
                        input logic [DW-1:0] d);
        l_ce0_n = 1'b0; l_ce1 = 1'b1; l_wr = wr; l_be = be; l_addr = a; l_wdata = d;
    endtask

    task automatic rset(input logic wr, input logic [NB-1:0] be, input logic [AW-1:0] a,
                        input logic [DW-1:0] d);
        r_ce0_n = 1'b0; r_ce1 = 1'b1; r_wr = wr; r_be = be; r_addr = a; r_wdata = d;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        idle();
        mrst_n = 1'b0;
        tick(); tick();
        chk("R9 reset l_int_n", 32'(l_int_n), 32'd1);
        chk("R9 reset r_int_n", 32'(r_int_n), 32'd1);
        chk("R9 reset l_rdata", 32'(l_rdata), 32'd0);
        chk("R9 reset r_rdata", 32'(r_rdata), 32'd0);
        mrst_n = 1'b1;
        tick();

        // fill all ordinary words with full byte selects
        for (int a = 0; a < DEPTH - 2; a++) begin
            d = DW'(a * 16'h0b35 + 16'h1234);
            lset(1'b1, '1, AW'(a), d);
            model[a] = d;
            tick();
        end
        idle();

        // R1/R2: sweep all byte-select patterns on write and read
        for (int a = 0; a < DEPTH - 2; a++) begin
            for (int wb = 0; wb < (1 << NB); wb++) begin
                d = DW'((a + 3) * 16'h3c5 ^ (wb * 16'h9117));
                lset(1'b1, NB'(wb), AW'(a), d);
                model[a] = (model[a] & ~bmask(NB'(wb))) | (d & bmask(NB'(wb)));
                tick();
                idle();
                rset(1'b0, '1, AW'(a), '0);
                lset(1'b0, NB'(wb), AW'(a), '0);
                tick();
                idle();
                chk("R1 byte write full read", 32'(r_rdata), 32'(model[a]));
                chk("R2 masked read", 32'(l_rdata), 32'(model[a] & bmask(NB'(wb))));
            end
        end

        // R3: disabled writes do nothing, disabled reads give zero
        lset(1'b1, '1, AW'(2), 16'hdead);
        l_ce0_n = 1'b1;
        tick();
        lset(1'b1, '1, AW'(2), 16'hbeef);
        l_ce1 = 1'b0;
        tick();
        idle();
        rset(1'b0, '1, AW'(2), '0);
        lset(1'b0, '1, AW'(2), '0);
        l_ce1 = 1'b0;
        tick();
        chk("R3 disabled write ignored", 32'(r_rdata), 32'(model[2]));
        chk("R3 disabled read zero", 32'(l_rdata), 32'd0);
        l_ce1 = 1'b1;
        tick();
        idle();
        chk("R3 one enabled cycle reactivates", 32'(l_rdata), 32'(model[2]));

        // R4: right reads a word that left writes in the same cycle
        lset(1'b1, '1, AW'(5), 16'h5a5a);
        rset(1'b0, '1, AW'(5), '0);
        tick();
        chk("R4 concurrent read gets old", 32'(r_rdata), 32'(model[5]));
        model[5] = 16'h5a5a;
        idle();
        rset(1'b0, '1, AW'(5), '0);
        tick();
        idle();
        chk("R4 new value after", 32'(r_rdata), 32'(model[5]));

        // R5: right writes left mailbox
        rset(1'b1, '1, L_BOX, 16'h0c0d);
        tick();
        idle();
        chk("R5 left int set", 32'(l_int_n), 32'd0);
        chk("R5 right int untouched", 32'(r_int_n), 32'd1);
        // R10: right reads left mailbox, left writes own mailbox
        rset(1'b0, '1, L_BOX, '0);
        tick();
        idle();
        chk("R10 other port read keeps flag", 32'(l_int_n), 32'd0);
        // left writes its own mailbox with no byte selects, so the message stays
        lset(1'b1, '0, L_BOX, 16'hffff);
        tick();
        idle();
        chk("R10 own write keeps flag", 32'(l_int_n), 32'd0);
        tick();
        chk("R10 quiet cycle keeps flag", 32'(l_int_n), 32'd0);
        // R7: left reads own mailbox
        lset(1'b0, '1, L_BOX, '0);
        tick();
        idle();
        chk("R7 left int cleared", 32'(l_int_n), 32'd1);
        chk("R7 left mailbox data", 32'(l_rdata), 32'h0c0d);

        // R6: left writes right mailbox, then right clears
        lset(1'b1, '1, R_BOX, 16'h7788);
        tick();
        idle();
        chk("R6 right int set", 32'(r_int_n), 32'd0);
        chk("R6 left int untouched", 32'(l_int_n), 32'd1);
        rset(1'b1, '1, R_BOX, 16'h1111);
        tick();
        idle();
        chk("R10 right own write keeps flag", 32'(r_int_n), 32'd0);
        rset(1'b0, '1, R_BOX, '0);
        tick();
        idle();
        chk("R7 right int cleared", 32'(r_int_n), 32'd1);
        chk("R7 right mailbox data", 32'(r_rdata), 32'h1111);

        // R8: set and clear of left flag in one cycle
        rset(1'b1, '1, L_BOX, 16'h2222);
        tick();
        lset(1'b0, '1, L_BOX, '0);
        rset(1'b1, '1, L_BOX, 16'h3333);
        tick();
        idle();
        chk("R8 set wins flag", 32'(l_int_n), 32'd0);
        chk("R8 read returns old message", 32'(l_rdata), 32'h2222);
        // R8 from a clear flag
        lset(1'b0, '1, L_BOX, '0);
        tick();
        idle();
        chk("R8 prep clear", 32'(l_int_n), 32'd1);
        lset(1'b0, '1, L_BOX, '0);
        rset(1'b1, '1, L_BOX, 16'h4444);
        tick();
        idle();
        chk("R8 set wins from clear", 32'(l_int_n), 32'd0);

        // R9: asynchronous reset between edges
        lset(1'b1, '1, R_BOX, 16'h9999);
        tick();
        idle();
        lset(1'b0, '1, AW'(3), '0);
        tick();
        idle();
        chk("R9 pre-reset right int low", 32'(r_int_n), 32'd0);
        #1 mrst_n = 1'b0;
        #0.5;
        chk("R9 async left int high", 32'(l_int_n), 32'd1);
        chk("R9 async right int high", 32'(r_int_n), 32'd1);
        chk("R9 async rdata zero", 32'(l_rdata), 32'd0);
        tick();
        mrst_n = 1'b1;
        tick();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule